// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block arbitrates between seven level-sensitive interrupt request lines and a processor that accepts a single 3-bit priority code. Each request first passes through a two-flop synchronizer. It is then qualified by two software-programmed per-level masks: an enable mask and a line-disable mask. The line-disable mask frees a level's request and acknowledge pins for other uses. The highest qualifying level drives the encoded priority output. Level 7 has the highest priority. A code of 0 means that no request is pending.

When the processor runs an acknowledge cycle, it presents the level it is servicing. In the same cycle, the controller raises the device-side acknowledge for that level. It also raises an autovector flag if software has selected autovectoring for that level. Software reaches the masks and a read-only pending view through a small 16-bit register port. Reads are combinational and writes take effect at a clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable, autovector-select and line-disable registers read 0, `ipl_o` is 0, `dev_ack_o` is 0 and `autovec_o` is 0.
- R2: The register at offset 0 (level enable), offset 1 (autovector select) and offset 2 (line disable) store `wdata_i[6:0]` on a write. Bit k of each register belongs to level k+1. Bits [15:7] always read 0.
- R3: A change on `irq_i` is visible on `ipl_o` and in the pending register after the second rising clock edge, and not after the first.
- R4: `ipl_o` equals k+1 for the highest k whose synchronized request bit `irq_i[k]` is set, whose enable bit is set and whose line-disable bit is clear. If no level qualifies, `ipl_o` is 0.
- R5: The read-only register at offset 3 returns, in bits [6:0], the synchronized requests ANDed with the enable mask and with the inverted line-disable mask. Writes to offset 3 change nothing.
- R6: A write to the enable or line-disable register affects `ipl_o` directly after the write's clock edge, with no added synchronizer delay.
- R7: While `iack_i` is high and `iack_lvl_i` is n in 1..7, `dev_ack_o[n-1]` is the only acknowledge bit set, in the same cycle. When `iack_i` is low or `iack_lvl_i` is 0, `dev_ack_o` is 0.
- R8: `autovec_o` is high exactly when an acknowledge is routed to level n (R7, R9) and bit n-1 of the autovector-select register is set.
- R9: When a level's line-disable bit is set, that level never contributes to `ipl_o` or to the pending register. An acknowledge at that level drives neither `dev_ack_o` nor `autovec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 7 | Raw level-sensitive requests; bit k is level k+1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset (0 enable, 1 autovector, 2 line disable, 3 pending) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i`, combinational |
| iack_i | input | 1 | Processor acknowledge cycle active |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Highest qualifying pending level, 0 when none |
| dev_ack_o | output | 7 | Device-side acknowledge, one bit per level |
| autovec_o | output | 1 | Current acknowledge should use an autovector |

## Verification
A request change is due on `ipl_o` and in the pending register two rising edges after it is driven. The bench drives on the falling edge and samples 1 ns after each of the two following rising edges. It expects the old value at the first sample and the new value at the second. Mask writes are due one edge after the write, so the check samples just after that single edge. Acknowledge routing and autovector selection are combinational, so those outputs are sampled 1 ns after the acknowledge inputs change, still inside the same low clock phase. All request patterns are swept against several mask configurations, and all acknowledge levels are swept with and without `iack_i`.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    REG_LVL_EN   = 2'd0,
    REG_AVEC_EN  = 2'd1,
    REG_LINE_DIS = 2'd2,
    REG_PEND     = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_LEVELS-1:0] pend_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_LEVELS-1:0] lvl_en_o,
  output logic [NUM_LEVELS-1:0] avec_en_o,
  output logic [NUM_LEVELS-1:0] line_dis_o
);
  logic [NUM_LEVELS-1:0] lvl_en_q, avec_en_q, line_dis_q;
  reg_addr_e             sel;

  assign sel = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_en_q   <= '0;
      avec_en_q  <= '0;
      line_dis_q <= '0;
    end else if (wr_en_i) begin
      case (sel)
        REG_LVL_EN:   lvl_en_q   <= wdata_i[NUM_LEVELS-1:0];
        REG_AVEC_EN:  avec_en_q  <= wdata_i[NUM_LEVELS-1:0];
        REG_LINE_DIS: line_dis_q <= wdata_i[NUM_LEVELS-1:0];
        default: ;  // pending view is read-only
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_LVL_EN:   rdata_o[NUM_LEVELS-1:0] = lvl_en_q;
      REG_AVEC_EN:  rdata_o[NUM_LEVELS-1:0] = avec_en_q;
      REG_LINE_DIS: rdata_o[NUM_LEVELS-1:0] = line_dis_q;
      REG_PEND:     rdata_o[NUM_LEVELS-1:0] = pend_i;
      default:      rdata_o = '0;
    endcase
  end

  assign lvl_en_o   = lvl_en_q;
  assign avec_en_o  = avec_en_q;
  assign line_dis_o = line_dis_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned LVL_W      = 3
) (
  input  logic [NUM_LEVELS-1:0] req_i,
  output logic [LVL_W-1:0]      lvl_o
);
  // ascending scan: last hit is the highest level
  always_comb begin
    lvl_o = '0;
    for (int k = 0; k < NUM_LEVELS; k++) begin
      if (req_i[k]) lvl_o = LVL_W'(k + 1);
    end
  end
endmodule

// File: rtl/irq_ack_route.sv
module irq_ack_route #(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned LVL_W      = 3
) (
  input  logic                  iack_i,
  input  logic [LVL_W-1:0]      iack_lvl_i,
  input  logic [NUM_LEVELS-1:0] avec_en_i,
  input  logic [NUM_LEVELS-1:0] line_dis_i,
  output logic [NUM_LEVELS-1:0] dev_ack_o,
  output logic                  autovec_o
);
  logic [NUM_LEVELS-1:0] hit;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
    assign hit[k] = iack_i && (iack_lvl_i == LVL_W'(k + 1)) && !line_dis_i[k];
  end

  assign dev_ack_o = hit;
  assign autovec_o = |(hit & avec_en_i);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_LEVELS  = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] irq_i,
  input  logic                  wr_en_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  iack_i,
  input  logic [LVL_W-1:0]      iack_lvl_i,
  output logic [LVL_W-1:0]      ipl_o,
  output logic [NUM_LEVELS-1:0] dev_ack_o,
  output logic                  autovec_o
);
  logic [NUM_LEVELS-1:0] irq_sync_q;
  logic [NUM_LEVELS-1:0] lvl_en, avec_en, line_dis;
  logic [NUM_LEVELS-1:0] pend;

  irq_sync #(.WIDTH(NUM_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_sync_q)
  );

  assign pend = irq_sync_q & lvl_en & ~line_dis;

  irq_regs #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pend_i    (pend),
    .rdata_o   (rdata_o),
    .lvl_en_o  (lvl_en),
    .avec_en_o (avec_en),
    .line_dis_o(line_dis)
  );

  irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_enc (
    .req_i(pend),
    .lvl_o(ipl_o)
  );

  irq_ack_route #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ack (
    .iack_i    (iack_i),
    .iack_lvl_i(iack_lvl_i),
    .avec_en_i (avec_en),
    .line_dis_i(line_dis),
    .dev_ack_o (dev_ack_o),
    .autovec_o (autovec_o)
  );
endmodule

module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned LVL_W      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LEVELS-1:0] irq_i,
  input logic                  iack_i,
  input logic [LVL_W-1:0]      iack_lvl_i,
  input logic [LVL_W-1:0]      ipl_o,
  input logic [NUM_LEVELS-1:0] dev_ack_o,
  input logic                  autovec_o,
  input logic [NUM_LEVELS-1:0] line_dis
);
  logic [NUM_LEVELS-1:0] ipl_bit;
  assign ipl_bit = (ipl_o == '0) ? '0 : (NUM_LEVELS'(1) << (ipl_o - LVL_W'(1)));

  // R7
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_ack_o));

  // R7
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iack_i || iack_lvl_i == '0) |-> dev_ack_o == '0);

  // R8
  avec_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autovec_o |-> (dev_ack_o != '0));

  // R9
  dis_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_ack_o & line_dis) == '0);

  // R9
  dis_no_ipl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_bit & line_dis) == '0);

  // R3
  ipl_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_o != '0) |-> ((ipl_bit & $past(irq_i, 2)) != '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .iack_i    (iack_i),
  .iack_lvl_i(iack_lvl_i),
  .ipl_o     (ipl_o),
  .dev_ack_o (dev_ack_o),
  .autovec_o (autovec_o),
  .line_dis  (line_dis)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        iack_i = 1'b0;
  logic [2:0]  iack_lvl_i = '0;
  logic [2:0]  ipl_o;
  logic [6:0]  dev_ack_o;
  logic        autovec_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_prio_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .iack_i(iack_i), .iack_lvl_i(iack_lvl_i),
    .ipl_o(ipl_o), .dev_ack_o(dev_ack_o), .autovec_o(autovec_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  function automatic logic [2:0] exp_ipl(input logic [6:0] q);
    logic [2:0] r = '0;
    for (int k = 0; k < 7; k++) if (q[k]) r = 3'(k + 1);
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [6:0]  en_cfg [4] = '{7'h7F, 7'h55, 7'h2A, 7'h7F};
    logic [6:0]  dis_cfg[4] = '{7'h00, 7'h00, 7'h00, 7'h41};
    logic [6:0]  av_cfg [3] = '{7'h7F, 7'h15, 7'h7F};
    logic [6:0]  ld_cfg [3] = '{7'h00, 7'h00, 7'h22};

    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk(ipl_o == 0, "R1 ipl", ipl_o, 0);
    chk(dev_ack_o == 0 && autovec_o == 0, "R1 ack", {autovec_o, dev_ack_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end

    // R2 readback, upper bits zero
    for (int a = 0; a < 3; a++) begin
      wr(2'(a), 16'hFFFF);
      rd(2'(a), v);
      chk(v == 16'h007F, "R2 all ones", v, 16'h007F);
      wr(2'(a), 16'hA5A5 ^ 16'(a));
      rd(2'(a), v);
      chk(v == ((16'hA5A5 ^ 16'(a)) & 16'h007F), "R2 pattern", v, (16'hA5A5 ^ 16'(a)) & 16'h007F);
    end
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);

    // R5 write to pending ignored
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v);
    chk(v == 0, "R5 pend write ignored", v, 0);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R5 pend write no side effect", v, 0);
    end

    // R3 two-edge latency
    wr(2'd0, 16'h007F);
    @(negedge clk_i); irq_i = 7'h40;
    @(posedge clk_i); #1;
    chk(ipl_o == 0, "R3 not after first edge", ipl_o, 0);
    @(posedge clk_i); #1;
    chk(ipl_o == 7, "R3 after second edge", ipl_o, 7);
    rd(2'd3, v);
    chk(v == 16'h0040, "R3 pending", v, 16'h0040);

    // R6 mask write takes effect right after its edge
    @(negedge clk_i); irq_i = 7'h7F;
    repeat (2) @(posedge clk_i);
    wr(2'd0, 16'h000F);
    chk(ipl_o == 4, "R6 enable write", ipl_o, 4);
    wr(2'd2, 16'h0008);
    chk(ipl_o == 3, "R6 disable write", ipl_o, 3);
    wr(2'd2, 16'h0000);

    // R4 R5 R9 exhaustive request sweep
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, {9'd0, en_cfg[c]});
      wr(2'd2, {9'd0, dis_cfg[c]});
      for (int p = 0; p < 128; p++) begin
        logic [6:0] q;
        @(negedge clk_i); irq_i = 7'(p); addr_i = 2'd3;
        repeat (2) @(posedge clk_i);
        #1;
        q = 7'(p) & en_cfg[c] & ~dis_cfg[c];
        chk(ipl_o == exp_ipl(q), dis_cfg[c] != 0 ? "R9 ipl sweep" : "R4 ipl sweep", ipl_o, exp_ipl(q));
        chk(rdata_o == {9'd0, q}, "R5 pending sweep", rdata_o, q);
      end
    end

    // R7 R8 R9 acknowledge sweep
    for (int c = 0; c < 3; c++) begin
      wr(2'd1, {9'd0, av_cfg[c]});
      wr(2'd2, {9'd0, ld_cfg[c]});
      for (int ia = 0; ia < 2; ia++) begin
        for (int l = 0; l < 8; l++) begin
          logic [6:0] ea;
          logic       eav;
          @(negedge clk_i);
          iack_i = 1'(ia); iack_lvl_i = 3'(l);
          #1;
          ea = (ia == 1 && l != 0) ? (7'd1 << (l - 1)) & ~ld_cfg[c] : 7'd0;
          eav = |(ea & av_cfg[c]);
          chk(dev_ack_o == ea, ld_cfg[c] != 0 ? "R9 ack routing" : "R7 ack routing", dev_ack_o, ea);
          chk(autovec_o == eav, "R8 autovec", autovec_o, eav);
        end
      end
    end
    @(negedge clk_i); iack_i = 1'b0; iack_lvl_i = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule